// File: doc/BRIEF.md
# Latency-Token Model Port

This block is a timed channel between two modules of a cycle-level performance model. Each model cycle, the producer writes one entry into it. The entry is either a message or an empty token. Each model cycle, the consumer takes one entry out. The queue starts out holding as many empty tokens as the configured latency. As a result, the entry the producer writes in its model cycle t is the entry the consumer takes in its model cycle t + latency.

The two sides only ever exchange whole entries, so they can run at different wall-clock rates. They may also be working on different model cycles at the same moment. The storage holds latency + 1 + extra entries, so the producer can run at least one model cycle ahead of the consumer before it has to stall.

On the producer side, a ready flag says there is room for an entry. On the consumer side, a ready flag says at least one entry is present. A consumer may advance only when every one of its input ports shows ready. When it advances, it pops one entry from each of those ports.

Top module: `lt_port`

## Requirements
- R1: While reset is asserted, and right after it is released, the port holds exactly LATENCY entries and every one of them is an empty token. Reading them gives rd_msg_vld_o = 0 and rd_data_o = 0 each time, and after the LATENCY-th read the port is empty.
- R2: With LATENCY = 0, the port comes out of reset empty (rd_rdy_o = 0, wr_rdy_o = 1). A message written into it can be read one clock later.
- R3: Capacity is DEPTH = LATENCY + 1 + EXTRA entries. wr_rdy_o is 0 exactly when DEPTH entries are held. A write offered while wr_rdy_o = 0 is dropped and does not appear at the consumer later.
- R4: rd_rdy_o is 0 exactly when no entry is held. While it is 0, rd_msg_vld_o and rd_data_o are 0, and a read request changes nothing.
- R5: The entry accepted as the producer's k-th write (k counted from 0) is presented as the consumer's (k + LATENCY)-th read. Its valid flag and payload are unchanged, and order is preserved.
- R6: An entry written with wr_msg_vld_i = 0 is an empty token. It reads back with rd_msg_vld_o = 0 and rd_data_o = 0, whatever wr_data_i was.
- R7: If a write and a read are both accepted on the same clock edge, the occupancy does not change, so neither ready flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; loads the initial tokens |
| wr_en_i | input | 1 | Producer offers one entry this clock |
| wr_msg_vld_i | input | 1 | 1 = the offered entry is a message, 0 = an empty token |
| wr_data_i | input | WIDTH | Message payload |
| wr_rdy_o | output | 1 | There is room for one entry |
| rd_en_i | input | 1 | Consumer takes the head entry this clock |
| rd_rdy_o | output | 1 | At least one entry is present |
| rd_msg_vld_o | output | 1 | The head entry is a message |
| rd_data_o | output | WIDTH | Payload of the head entry (0 for a token or when empty) |

## Verification
The hardest situation to reach is a full port, because the pre-loaded tokens and the single spare slot leave only one write of slack. The bench gets there by releasing reset and then writing once with the consumer idle. It then offers a second write, which must be dropped. It drains the port to show that only the first message survives, behind the initial tokens. The end-to-end latency is checked in a lockstep run that mixes messages and tokens, where every read is compared with the write made LATENCY model cycles earlier. A second instance with zero latency covers the case where the port starts empty.

// File: rtl/lt_pkg.sv
`timescale 1ns/1ps
package lt_pkg;
  // index width that stays legal for depth 1
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/lt_ring_ptr.sv
`timescale 1ns/1ps
module lt_ring_ptr #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned PTR_W = 2,
  parameter int unsigned INIT  = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [PTR_W-1:0] ptr_o
);
  localparam logic [PTR_W-1:0] LAST   = PTR_W'(DEPTH - 1);
  localparam logic [PTR_W-1:0] INIT_P = PTR_W'(INIT % DEPTH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_o <= INIT_P;
    else if (adv_i) ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
  end

  AST_PTR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_o <= LAST); // R3
endmodule

// File: rtl/lt_slots.sv
`timescale 1ns/1ps
module lt_slots #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned WIDTH = 8,
  parameter int unsigned PTR_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [PTR_W-1:0] wr_ptr_i,
  input  logic             wr_vld_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic [PTR_W-1:0] rd_ptr_i,
  output logic             rd_vld_o,
  output logic [WIDTH-1:0] rd_data_o
);
  logic [WIDTH-1:0] data_q [DEPTH];
  logic [DEPTH-1:0] vld_q;

  // reset clears every slot, so the pre-loaded entries are tokens
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) data_q[i] <= '0;
    end else if (wr_en_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wr_ptr_i == PTR_W'(i)) begin
          vld_q[i]  <= wr_vld_i;
          data_q[i] <= wr_vld_i ? wr_data_i : '0;
        end
      end
    end
  end

  always_comb begin
    rd_vld_o  = 1'b0;
    rd_data_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_ptr_i == PTR_W'(i)) begin
        rd_vld_o  = vld_q[i];
        rd_data_o = data_q[i];
      end
    end
  end
endmodule

// File: rtl/lt_occupancy.sv
`timescale 1ns/1ps
module lt_occupancy #(
  parameter int unsigned DEPTH   = 4,
  parameter int unsigned LATENCY = 3,
  parameter int unsigned CNT_W   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             not_full_o,
  output logic             not_empty_o
);
  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] INIT_C = CNT_W'(LATENCY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= INIT_C;
    else begin
      unique case ({push_i, pop_i})
        2'b10:   cnt_o <= cnt_o + 1'b1;
        2'b01:   cnt_o <= cnt_o - 1'b1;
        default: cnt_o <= cnt_o;
      endcase
    end
  end

  assign not_full_o  = (cnt_o != FULL_C);
  assign not_empty_o = (cnt_o != '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= FULL_C); // R3
  AST_BOTH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i) |=> $stable(cnt_o)); // R7
endmodule

// File: rtl/lt_port.sv
`timescale 1ns/1ps
module lt_port #(
  parameter int unsigned LATENCY = 3,
  parameter int unsigned WIDTH   = 8,
  parameter int unsigned EXTRA   = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_msg_vld_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic             wr_rdy_o,
  input  logic             rd_en_i,
  output logic             rd_rdy_o,
  output logic             rd_msg_vld_o,
  output logic [WIDTH-1:0] rd_data_o
);
  localparam int unsigned DEPTH = LATENCY + 1 + EXTRA;
  localparam int unsigned PTR_W = lt_pkg::idx_w(DEPTH);
  localparam int unsigned CNT_W = lt_pkg::idx_w(DEPTH + 1);

  logic             push, pop;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;
  logic             head_vld;
  logic [WIDTH-1:0] head_data;

  assign push = wr_en_i && wr_rdy_o;
  assign pop  = rd_en_i && rd_rdy_o;

  // write pointer starts past the pre-loaded tokens
  lt_ring_ptr #(.DEPTH(DEPTH), .PTR_W(PTR_W), .INIT(LATENCY)) i_wr_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(push), .ptr_o(wr_ptr));

  lt_ring_ptr #(.DEPTH(DEPTH), .PTR_W(PTR_W), .INIT(0)) i_rd_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(pop), .ptr_o(rd_ptr));

  lt_slots #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PTR_W(PTR_W)) i_slots (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(push), .wr_ptr_i(wr_ptr), .wr_vld_i(wr_msg_vld_i), .wr_data_i(wr_data_i),
    .rd_ptr_i(rd_ptr), .rd_vld_o(head_vld), .rd_data_o(head_data));

  lt_occupancy #(.DEPTH(DEPTH), .LATENCY(LATENCY), .CNT_W(CNT_W)) i_occ (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push), .pop_i(pop),
    .cnt_o(cnt), .not_full_o(wr_rdy_o), .not_empty_o(rd_rdy_o));

  assign rd_msg_vld_o = rd_rdy_o && head_vld;
  assign rd_data_o    = rd_rdy_o ? head_data : '0;

  AST_PTR_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((int'(wr_ptr) + int'(DEPTH) - int'(rd_ptr)) % int'(DEPTH)) == (int'(cnt) % int'(DEPTH))); // R5
  AST_TOKEN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_rdy_o && !rd_msg_vld_o) |-> (rd_data_o == '0)); // R6
  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_rdy_o && !pop) |=> !wr_rdy_o); // R3
  AST_EMPTY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !rd_rdy_o && !push) |=> !rd_rdy_o); // R4
  AST_BOTH_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && pop) |=> (wr_rdy_o == $past(wr_rdy_o)) && (rd_rdy_o == $past(rd_rdy_o))); // R7
endmodule

// File: tb/test_lt_port.sv
`timescale 1ns/1ps
module test_lt_port;
  localparam int unsigned LAT = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic       we = 0, mv = 0, re = 0;
  logic [7:0] wd = '0;
  logic       wr_rdy, rd_rdy, rd_mv;
  logic [7:0] rd_d;

  logic       z_we = 0, z_mv = 0, z_re = 0;
  logic [7:0] z_wd = '0;
  logic       z_wr_rdy, z_rd_rdy, z_rd_mv;
  logic [7:0] z_rd_d;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  lt_port #(.LATENCY(LAT), .WIDTH(8), .EXTRA(0)) i_lt_port (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_en_i(we), .wr_msg_vld_i(mv), .wr_data_i(wd), .wr_rdy_o(wr_rdy),
    .rd_en_i(re), .rd_rdy_o(rd_rdy), .rd_msg_vld_o(rd_mv), .rd_data_o(rd_d));

  lt_port #(.LATENCY(0), .WIDTH(8), .EXTRA(0)) i_lt_port_z (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_en_i(z_we), .wr_msg_vld_i(z_mv), .wr_data_i(z_wd), .wr_rdy_o(z_wr_rdy),
    .rd_en_i(z_re), .rd_rdy_o(z_rd_rdy), .rd_msg_vld_o(z_rd_mv), .rd_data_o(z_rd_d));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // drive at the falling edge, settle, outputs then show state before next rise
  task automatic cyc(input logic w, input logic v, input logic [7:0] d, input logic r);
    @(negedge clk);
    we = w; mv = v; wd = d; re = r;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    we = 0; re = 0; mv = 0; wd = '0;
    z_we = 0; z_re = 0; z_mv = 0; z_wd = '0;
    rst_ni = 1'b0;
    #1;
    chk("R1 in-reset rd_rdy", rd_rdy, 1);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic test_reset_tokens();
    do_reset();
    for (int i = 0; i < LAT; i++) begin
      cyc(0, 0, 8'h00, 1);
      chk("R1 rd_rdy", rd_rdy, 1);
      chk("R1 token vld", rd_mv, 0);
      chk("R1 token data", rd_d, 0);
    end
    cyc(0, 0, 8'h00, 1);
    chk("R4 empty after drain", rd_rdy, 0);
    chk("R4 empty vld", rd_mv, 0);
    cyc(0, 0, 8'h00, 0);
    chk("R4 read on empty ignored", rd_rdy, 0);
    chk("R4 wr_rdy", wr_rdy, 1);
  endtask

  task automatic test_lockstep();
    logic       hv [32];
    logic [7:0] hd [32];
    do_reset();
    for (int t = 0; t < 12; t++) begin
      logic v;
      v = (t % 3) != 1;
      hv[t] = v;
      hd[t] = v ? 8'(8'h10 + t) : 8'h00;
      cyc(1, v, 8'(8'h10 + t), 1);
      chk("R7 wr_rdy steady", wr_rdy, 1);
      chk("R7 rd_rdy steady", rd_rdy, 1);
      if (t < LAT) begin
        chk("R5 initial token", rd_mv, 0);
      end else begin
        chk("R5 delayed vld", rd_mv, hv[t-LAT]);
        chk(hv[t-LAT] ? "R5 delayed data" : "R6 token data zero", rd_d, hd[t-LAT]);
      end
    end
  endtask

  task automatic test_full();
    do_reset();
    cyc(1, 1, 8'h5A, 0);
    chk("R3 room before", wr_rdy, 1);
    cyc(1, 1, 8'hEE, 0);
    chk("R3 full", wr_rdy, 0);
    cyc(0, 0, 8'h00, 0);
    chk("R3 still full", wr_rdy, 0);
    for (int i = 0; i < LAT; i++) begin
      cyc(0, 0, 8'h00, 1);
      chk("R3 leading token", rd_mv, 0);
    end
    cyc(0, 0, 8'h00, 1);
    chk("R3 kept msg vld", rd_mv, 1);
    chk("R3 kept msg data", rd_d, 8'h5A);
    cyc(0, 0, 8'h00, 0);
    chk("R3 dropped write absent", rd_rdy, 0);
  endtask

  task automatic test_token_payload();
    do_reset();
    for (int i = 0; i < LAT; i++) cyc(0, 0, 8'h00, 1);
    cyc(1, 0, 8'hC3, 0);
    cyc(0, 0, 8'h00, 0);
    chk("R6 token present", rd_rdy, 1);
    chk("R6 token vld", rd_mv, 0);
    chk("R6 token data masked", rd_d, 0);
  endtask

  task automatic test_zero_latency();
    do_reset();
    #1;
    chk("R2 starts empty", z_rd_rdy, 0);
    chk("R2 room", z_wr_rdy, 1);
    @(negedge clk);
    z_we = 1; z_mv = 1; z_wd = 8'h33;
    @(negedge clk);
    z_we = 0; z_mv = 0; z_wd = 8'h00;
    #1;
    chk("R2 present next clock", z_rd_rdy, 1);
    chk("R2 vld", z_rd_mv, 1);
    chk("R2 data", z_rd_d, 8'h33);
    chk("R2 depth one full", z_wr_rdy, 0);
    @(negedge clk);
    z_re = 1;
    @(negedge clk);
    z_re = 0;
    #1;
    chk("R2 drained", z_rd_rdy, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    test_reset_tokens();
    test_lockstep();
    test_full();
    test_token_payload();
    test_zero_latency();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule